// File: doc/BRIEF.md
# Auto-Incrementing Colour Palette Port

This block holds a 256-entry colour lookup table whose entries carry 18 bits, six each for red, green and blue. A host loads or inspects the table over a narrow byte interface: it first writes an entry number to one of two index ports, one that opens a loading sequence and one that opens an inspection sequence. It then moves colour bytes through a single shared data port, red first, then green, then blue. After the third byte of an entry the entry number steps on by one, so a whole run of entries streams through the data port without another index write.

While the host works on the table, a separate pixel port turns an 8-bit pixel code into its 18-bit colour with one cycle of delay. A loaded entry reaches the table only once its blue byte arrives, so the pixel side never sees an entry with only some of its components new.

Top module: `clut_dac`

## Requirements
- R1: After reset the entry pointer is 0, the component step is red, the block is in load mode and `host_rdata` is 0, so three data-port writes with no index write first load entry 0. Table contents are not reset.
- R2: `host_sel` selects the target of an access: 0 is the data port, 1 the load-index port, 2 the inspect-index port; code 3 selects nothing and an access with it changes no state. A pixel entry is packed with red in bits 17:12, green in 11:6 and blue in 5:0.
- R3: A write to either index port loads the entry pointer from `host_wdata`, returns the component step to red and sets load mode (code 1) or inspect mode (code 2).
- R4: In load mode, data-port writes are taken as red, green, blue in that order, and only bits 5:0 of each byte are kept.
- R5: Red and green are held aside and the table entry is written only on the blue byte; before that the pixel port still returns the old entry.
- R6: After the blue byte the pointer advances by one, wrapping from 255 to 0.
- R7: In inspect mode a data-port read returns red, green, blue of the pointed entry in turn, in bits 5:0 with bits 7:6 zero; `host_rdata` is valid from the clock edge that takes the read and holds until the next accepted read.
- R8: After the third inspect read the pointer advances by one, wrapping from 255 to 0.
- R9: A data-port write in inspect mode and a data-port read in load mode are ignored: table, pointer, component step and `host_rdata` stay as they were.
- R10: When `host_we` and `host_re` are both high, only the write is carried out.
- R11: `pix_rgb` shows the entry addressed by `pix_idx` at the previous clock edge, as the table stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_sel | input | 2 | Access target code |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 18 | Colour of the looked-up entry |

## Verification
The hardest situation to reach is a mode clash in the middle of an entry: an inspect read or a stray code-3 access landing between the red and blue bytes of a load, or a load byte arriving while in inspect mode. Such accesses must leave the staged components and step untouched. Directed sequences place these accesses after exactly one or two components, and a long seeded random run mixes all access codes and strobe pairs so that clashes fall at every component step and across the pointer wrap.

// File: rtl/clut_pkg.sv
package clut_pkg;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_LIDX = 2'd1,
      SEL_IIDX = 2'd2,
      SEL_NONE = 2'd3
   } host_sel_e;

   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } comp_phase_e;

   typedef enum logic {
      MODE_LOAD    = 1'b0,
      MODE_INSPECT = 1'b1
   } acc_mode_e;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
   import clut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 8,
   parameter int CW     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_we,
   input  logic                 host_re,
   input  logic [1:0]           host_sel,
   input  logic [DATA_W-1:0]    host_wdata,
   input  logic [3*CW-1:0]      cur_entry,
   output logic [IDX_W-1:0]     ptr,
   output comp_phase_e          phase,
   output acc_mode_e            mode,
   output logic                 cmt_en,
   output logic [3*CW-1:0]      cmt_data,
   output logic [DATA_W-1:0]    host_rdata
);

   localparam int ENTRY_W = 3 * CW;

   initial begin : elab_chk
      assert (CW <= DATA_W) else $fatal(1, "component wider than data byte");
      assert (IDX_W <= DATA_W) else $fatal(1, "index wider than data byte");
   end

   host_sel_e   sel;
   logic        idx_wr;
   logic        data_wr;
   logic        data_rd;
   logic        step;
   logic        last_comp;
   logic [CW-1:0] stg_r;
   logic [CW-1:0] stg_g;
   logic [CW-1:0] rd_comp;

   assign sel       = host_sel_e'(host_sel);
   assign idx_wr    = host_we && (sel == SEL_LIDX || sel == SEL_IIDX);
   assign data_wr   = host_we && sel == SEL_DATA && mode == MODE_LOAD;
   assign data_rd   = host_re && !host_we && sel == SEL_DATA && mode == MODE_INSPECT;
   assign step      = data_wr || data_rd;
   assign last_comp = (phase == PH_BLU);

   always_comb begin
      case (phase)
         PH_RED:  rd_comp = cur_entry[ENTRY_W-1 -: CW];
         PH_GRN:  rd_comp = cur_entry[2*CW-1 -: CW];
         default: rd_comp = cur_entry[CW-1:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr   <= '0;
         phase <= PH_RED;
         mode  <= MODE_LOAD;
      end else if (idx_wr) begin
         ptr   <= host_wdata[IDX_W-1:0];
         phase <= PH_RED;
         mode  <= (sel == SEL_IIDX) ? MODE_INSPECT : MODE_LOAD;
      end else if (step) begin
         case (phase)
            PH_RED:  phase <= PH_GRN;
            PH_GRN:  phase <= PH_BLU;
            default: phase <= PH_RED;
         endcase
         if (last_comp) ptr <= ptr + IDX_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_r <= '0;
         stg_g <= '0;
      end else if (data_wr) begin
         if (phase == PH_RED) stg_r <= host_wdata[CW-1:0];
         if (phase == PH_GRN) stg_g <= host_wdata[CW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) host_rdata <= '0;
      else if (data_rd) host_rdata <= DATA_W'(rd_comp);
   end

   assign cmt_en   = data_wr && last_comp;
   assign cmt_data = {stg_r, stg_g, host_wdata[CW-1:0]};

endmodule

// File: rtl/clut_store.sv
module clut_store #(
   parameter int IDX_W      = 8,
   parameter int ENTRY_W    = 18,
   parameter int PIX_STAGES = 1
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_addr,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [IDX_W-1:0]   host_addr,
   output logic [ENTRY_W-1:0] host_entry,
   input  logic [IDX_W-1:0]   pix_addr,
   output logic [ENTRY_W-1:0] pix_entry
);

   localparam int DEPTH = 1 << IDX_W;

   initial begin : elab_chk
      assert (PIX_STAGES == 1 || PIX_STAGES == 2)
         else $fatal(1, "pixel stages must be 1 or 2");
   end

   logic [ENTRY_W-1:0] tbl [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) tbl[wr_addr] <= wr_data;
   end

   assign host_entry = tbl[host_addr];

   generate
      if (PIX_STAGES == 1) begin : g_pix1
         logic [ENTRY_W-1:0] pix_q;
         always_ff @(posedge clk) pix_q <= tbl[pix_addr];
         assign pix_entry = pix_q;
      end else begin : g_pix2
         logic [ENTRY_W-1:0] pix_q0;
         logic [ENTRY_W-1:0] pix_q1;
         always_ff @(posedge clk) begin
            pix_q0 <= tbl[pix_addr];
            pix_q1 <= pix_q0;
         end
         assign pix_entry = pix_q1;
      end
   endgenerate

endmodule

// File: rtl/clut_dac.sv
module clut_dac
   import clut_pkg::*;
#(
   parameter int IDX_W      = 8,
   parameter int DATA_W     = 8,
   parameter int CW         = 6,
   parameter int PIX_STAGES = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_we,
   input  logic                host_re,
   input  logic [1:0]          host_sel,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   input  logic [IDX_W-1:0]    pix_idx,
   output logic [3*CW-1:0]     pix_rgb
);

   localparam int ENTRY_W = 3 * CW;

   logic [IDX_W-1:0]   seq_ptr;
   comp_phase_e        seq_phase;
   acc_mode_e          seq_mode;
   logic               cmt_en;
   logic [ENTRY_W-1:0] cmt_data;
   logic [ENTRY_W-1:0] cur_entry;

   clut_seq #(
      .IDX_W (IDX_W),
      .DATA_W(DATA_W),
      .CW    (CW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (host_we),
      .host_re   (host_re),
      .host_sel  (host_sel),
      .host_wdata(host_wdata),
      .cur_entry (cur_entry),
      .ptr       (seq_ptr),
      .phase     (seq_phase),
      .mode      (seq_mode),
      .cmt_en    (cmt_en),
      .cmt_data  (cmt_data),
      .host_rdata(host_rdata)
   );

   clut_store #(
      .IDX_W     (IDX_W),
      .ENTRY_W   (ENTRY_W),
      .PIX_STAGES(PIX_STAGES)
   ) u_store (
      .clk       (clk),
      .wr_en     (cmt_en),
      .wr_addr   (seq_ptr),
      .wr_data   (cmt_data),
      .host_addr (seq_ptr),
      .host_entry(cur_entry),
      .pix_addr  (pix_idx),
      .pix_entry (pix_rgb)
   );

endmodule

// File: rtl/clut_chk.sv
module clut_chk #(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 8,
   parameter int CW     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic              host_re,
   input logic [1:0]        host_sel,
   input logic [DATA_W-1:0] host_rdata,
   input logic [IDX_W-1:0]  ptr,
   input logic [1:0]        phase,
   input logic              mode
);

   a_r3_index_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && (host_sel == 2'd1 || host_sel == 2'd2)) |=> (phase == 2'd0));

   a_r4_red_then_green: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_sel == 2'd0 && !mode && phase == 2'd0) |=> (phase == 2'd1));

   a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 2'd3);

   a_r6_ptr_steps_on_blue: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_sel == 2'd0 && !mode && phase == 2'd2)
         |=> (ptr == $past(ptr) + IDX_W'(1)));

   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_we && !host_re) |=> ($stable(ptr) && $stable(phase) && $stable(host_rdata)));

   a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_re) |=> $stable(host_rdata));

   generate
      if (CW < DATA_W) begin : g_pad
         a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            host_rdata[DATA_W-1:CW] == '0);
      end
   endgenerate

endmodule

bind clut_dac clut_chk #(
   .IDX_W (IDX_W),
   .DATA_W(DATA_W),
   .CW    (CW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_we   (host_we),
   .host_re   (host_re),
   .host_sel  (host_sel),
   .host_rdata(host_rdata),
   .ptr       (seq_ptr),
   .phase     (seq_phase),
   .mode      (seq_mode)
);

// File: tb/clut_dac_tb.sv
module clut_dac_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        host_we;
   logic        host_re;
   logic [1:0]  host_sel;
   logic [7:0]  host_wdata;
   logic [7:0]  host_rdata;
   logic [7:0]  pix_idx;
   logic [17:0] pix_rgb;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   logic [17:0] m_tbl [256];
   logic [7:0]  m_ptr;
   int          m_ph;
   bit          m_insp;
   logic [5:0]  m_sr, m_sg;
   logic [7:0]  m_rd;

   always #5 clk = ~clk;

   clut_dac dut_i (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
      .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] comp_of(input logic [17:0] e, input int ph);
      case (ph)
         0:       return e[17:12];
         1:       return e[11:6];
         default: return e[5:0];
      endcase
   endfunction

   task automatic op(input bit we, input bit re, input logic [1:0] sel,
                     input logic [7:0] d, input string req);
      @(negedge clk);
      host_we = we; host_re = re; host_sel = sel; host_wdata = d;
      @(posedge clk);
      #1;
      host_we = 0; host_re = 0;
      if (we) begin
         if (sel == 2'd1 || sel == 2'd2) begin
            m_ptr = d; m_ph = 0; m_insp = (sel == 2'd2);
         end else if (sel == 2'd0 && !m_insp) begin
            if (m_ph == 0) m_sr = d[5:0];
            else if (m_ph == 1) m_sg = d[5:0];
            else begin
               m_tbl[m_ptr] = {m_sr, m_sg, d[5:0]};
               m_ptr++;
            end
            m_ph = (m_ph + 1) % 3;
         end
      end else if (re && sel == 2'd0 && m_insp) begin
         m_rd = {2'b00, comp_of(m_tbl[m_ptr], m_ph)};
         if (m_ph == 2) m_ptr++;
         m_ph = (m_ph + 1) % 3;
      end
      chk(req, host_rdata, m_rd);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d, input string req);
      op(1, 0, sel, d, req);
   endtask

   task automatic rd(input string req);
      op(0, 1, 2'd0, 8'h00, req);
   endtask

   task automatic pix_chk(input logic [7:0] idx, input string req);
      @(negedge clk);
      pix_idx = idx;
      @(posedge clk);
      #1;
      chk(req, pix_rgb, m_tbl[idx]);
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 60000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<60000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [17:0] old5;
      void'($urandom(32'h5eed_c10b));
      rst_n = 0; host_we = 0; host_re = 0; host_sel = 0; host_wdata = 0; pix_idx = 0;
      m_ptr = 0; m_ph = 0; m_insp = 0; m_sr = 0; m_sg = 0; m_rd = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 reset rdata", host_rdata, 8'h00);

      // R1: no index write needed for entry 0
      wr(2'd0, 8'h2a, "R1"); wr(2'd0, 8'h15, "R1"); wr(2'd0, 8'h07, "R1");
      pix_chk(8'd0, "R1 entry0 loaded");

      // fill 1..255 then wrap into 0 (R6)
      wr(2'd1, 8'd1, "R3");
      for (int i = 0; i < 255 * 3; i++) wr(2'd0, 8'($urandom), "R4");
      pix_chk(8'd255, "R6 last entry");
      wr(2'd0, 8'h11, "R6"); wr(2'd0, 8'h22, "R6"); wr(2'd0, 8'h33, "R6");
      pix_chk(8'd0, "R6 wrap to 0");

      // R4: only low six bits kept
      wr(2'd1, 8'd9, "R4"); wr(2'd0, 8'hff, "R4"); wr(2'd0, 8'hc1, "R4"); wr(2'd0, 8'h80, "R4");
      pix_chk(8'd9, "R4 masked");
      chk("R4 packing", m_tbl[9], {6'h3f, 6'h01, 6'h00});

      // R5: commit only on blue
      old5 = m_tbl[5];
      wr(2'd1, 8'd5, "R5"); wr(2'd0, 8'h0c, "R5"); wr(2'd0, 8'h0d, "R5");
      pix_chk(8'd5, "R5 before blue");
      chk("R5 old kept", pix_rgb, old5);
      wr(2'd0, 8'h0e, "R5");
      pix_chk(8'd5, "R5 after blue");

      // R7: inspect order, zero upper bits, hold
      wr(2'd2, 8'd9, "R3");
      rd("R7 red"); chk("R7 red val", host_rdata, 8'h3f);
      rd("R7 green"); chk("R7 green val", host_rdata, 8'h01);
      rd("R7 blue"); chk("R7 blue val", host_rdata, 8'h00);
      @(negedge clk); @(negedge clk);
      chk("R7 hold", host_rdata, 8'h00);

      // R3: index rewrite restarts at red
      wr(2'd2, 8'd9, "R3"); rd("R3"); rd("R3");
      wr(2'd2, 8'd9, "R3"); rd("R3 red again");
      chk("R3 red value", host_rdata, 8'h3f);

      // R8: inspect wrap
      wr(2'd2, 8'd255, "R8");
      for (int i = 0; i < 6; i++) rd("R8 wrap");

      // R9: mode clashes
      wr(2'd2, 8'd20, "R9"); rd("R9");
      wr(2'd0, 8'h15, "R9 write in inspect");
      rd("R9 next is green"); rd("R9");
      pix_chk(8'd20, "R9 table untouched");
      wr(2'd1, 8'd30, "R9"); wr(2'd0, 8'h01, "R9");
      op(0, 1, 2'd0, 8'h00, "R9 read in load");
      wr(2'd0, 8'h02, "R9"); wr(2'd0, 8'h03, "R9");
      pix_chk(8'd30, "R9 load intact");

      // R2 and R10: code 3 ignored, write wins over read
      wr(2'd1, 8'd40, "R2"); wr(2'd0, 8'h21, "R2");
      wr(2'd3, 8'h99, "R2 code3");
      op(1, 1, 2'd0, 8'h22, "R10 both strobes");
      wr(2'd0, 8'h23, "R10");
      pix_chk(8'd40, "R10 entry");
      chk("R2 entry40", m_tbl[40], {6'h21, 6'h22, 6'h23});

      // R11: latency
      pix_chk(8'd9, "R11");
      @(negedge clk);
      pix_idx = 8'd5;
      #1;
      chk("R11 before edge", pix_rgb, m_tbl[9]);
      @(posedge clk);
      #1;
      chk("R11 after edge", pix_rgb, m_tbl[5]);

      // seeded random mix
      for (int i = 0; i < 3000; i++) begin
         int k;
         k = $urandom_range(0, 9);
         if (k < 4)       op(1, 0, 2'd0, 8'($urandom), "R4 rnd");
         else if (k < 6)  op(0, 1, 2'd0, 8'h00, "R7 rnd");
         else if (k == 6) op(1, 0, 2'($urandom_range(1, 2)), 8'($urandom), "R3 rnd");
         else if (k == 7) op(1'($urandom), 1'($urandom), 2'd3, 8'($urandom), "R2 rnd");
         else if (k == 8) op(1, 1, 2'($urandom), 8'($urandom), "R10 rnd");
         else             pix_chk(8'($urandom), "R11 rnd");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule